// File: doc/BRIEF.md
# Device Status Error Logger

This block holds the 16-bit device status word of a PCI Express-style configuration space. The device core raises single-cycle pulses when it detects a correctable, non-fatal, fatal or unsupported-request error. Each pulse sets a sticky flag, and the flag stays set until software writes a one to it. An unsupported request always sets its own flag. It also sets either the fatal or the non-fatal summary flag, depending on a severity control.

The block sits behind a simple configuration port. The port is dword addressed and carries 32 bits of data with four byte enables. The status word occupies byte offset AAh–ABh, which is the upper half of the dword at A8h. Reads are combinational and have no side effects. Error-reporting enables and error masks are brought into the block, but they never gate logging.

Top module: `dsts_err_log`

## Requirements
- R1: After reset, all status bits are 0. The dword at A8h reads 0000_0000h.
- R2: The status word is returned in read data bits 31:16 whenever the address selects the dword at A8h (address bits above 1 equal A8h>>2). Read data bits 15:0 always read 0. Every other address reads 0.
- R3: A pulse on the correctable, non-fatal or fatal event input sets status bit 0, 1 or 2 respectively, visible from the cycle after the pulse. The bit then stays 1 until it is cleared.
- R4: An unsupported-request pulse sets status bit 3. It also sets bit 1 when the severity input is 0, or bit 2 when the severity input is 1.
- R5: A write to A8h with byte enable 2 set clears each of status bits 3:0 whose write data bit (19:16) is 1. Bits written with 0 keep their value.
- R6: A write with byte enable 2 clear, or a write to any other dword address, changes no status bit.
- R7: When an event sets a bit in the same cycle that a write clears it, the bit ends up 1.
- R8: Status bit 5 (transactions pending), bit 4 and bits 15:6 always read 0, whatever is written to them.
- R9: The reporting-enable and mask inputs have no effect on which bits get set.
- R10: Read data follows the address combinationally in the same cycle, and presenting a read address does not change any bit.
- R11: Several events arriving in one cycle set all of their matching bits together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_addr_i | input | 12 | Configuration byte address (dword aligned use) |
| cfg_wr_i | input | 1 | Write strobe |
| cfg_be_i | input | 4 | Byte enables of the write |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Combinational read data |
| ev_corr_i | input | 1 | Correctable error pulse |
| ev_nonfatal_i | input | 1 | Non-fatal error pulse |
| ev_fatal_i | input | 1 | Fatal error pulse |
| ev_unsup_i | input | 1 | Unsupported request pulse |
| unsup_sev_fatal_i | input | 1 | Unsupported request severity, 1 = fatal |
| rpt_en_i | input | 4 | Error reporting enables (do not gate logging) |
| uncor_mask_i | input | 32 | Uncorrectable error mask (does not gate logging) |
| cor_mask_i | input | 32 | Correctable error mask (does not gate logging) |

## Verification
The bench uses the default parameters: a 12-bit address, a status dword at A8h with the status word in lane 2 and up, and 32-bit masks. Random addresses are drawn from 00h–FFh, with half of them forced to A8h. This mix reaches both a register hit and the neighbouring dword at ACh, so decode misses and lane-gated writes are exercised alongside clears. Random event bursts, random severity and random masks and enables run against the sticky bits, so set-over-clear collisions occur naturally. Directed cases also pin these collisions down.

// File: rtl/dsts_pkg.sv
package dsts_pkg;
  localparam int STS_W   = 16;
  localparam int N_ERR   = 4;
  localparam int B_CORR  = 0;
  localparam int B_NFAT  = 1;
  localparam int B_FAT   = 2;
  localparam int B_UNSUP = 3;
  localparam int B_TPEND = 5;
  typedef logic [N_ERR-1:0] err_vec_t;
endpackage

// File: rtl/dsts_evt_route.sv
module dsts_evt_route
  import dsts_pkg::*;
(
  input  logic     ev_corr_i,
  input  logic     ev_nonfatal_i,
  input  logic     ev_fatal_i,
  input  logic     ev_unsup_i,
  input  logic     unsup_sev_fatal_i,
  output err_vec_t set_o
);
  always_comb begin
    set_o          = '0;
    set_o[B_CORR]  = ev_corr_i;
    set_o[B_NFAT]  = ev_nonfatal_i | (ev_unsup_i & ~unsup_sev_fatal_i);
    set_o[B_FAT]   = ev_fatal_i    | (ev_unsup_i &  unsup_sev_fatal_i);
    set_o[B_UNSUP] = ev_unsup_i;
  end
endmodule

// File: rtl/dsts_w1c_bit.sv
module dsts_w1c_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;   // set beats clear
    else if (clr_i)  q_o <= 1'b0;
  end

  a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o);
  a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !q_o);
  a_r3_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/dsts_cfg_port.sv
module dsts_cfg_port
  import dsts_pkg::*;
#(
  parameter int          ADDR_W   = 12,
  parameter logic [11:0] REG_ADDR = 12'hA8,
  parameter int          STS_LANE = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [3:0]        be_i,
  input  logic [31:0]       wdata_i,
  input  err_vec_t          sts_i,
  output err_vec_t          clr_o,
  output logic [31:0]       rdata_o
);
  localparam int LSB = STS_LANE * 8;
  localparam logic [ADDR_W-1:0] REG_A = ADDR_W'(REG_ADDR);

  logic             hit;
  logic [STS_W-1:0] sts_word;

  assign hit = (addr_i[ADDR_W-1:2] == REG_A[ADDR_W-1:2]);

  always_comb begin
    sts_word            = '0;   // TP, reserved hardwired 0
    sts_word[N_ERR-1:0] = sts_i;
    rdata_o             = '0;
    if (hit) rdata_o[LSB +: STS_W] = sts_word;
  end

  assign clr_o = (wr_i && hit && be_i[STS_LANE]) ? wdata_i[LSB +: N_ERR] : '0;
endmodule

// File: rtl/dsts_err_log.sv
module dsts_err_log
  import dsts_pkg::*;
#(
  parameter int          ADDR_W   = 12,
  parameter logic [11:0] REG_ADDR = 12'hA8,
  parameter int          MASK_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic              cfg_wr_i,
  input  logic [3:0]        cfg_be_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  input  logic              ev_corr_i,
  input  logic              ev_nonfatal_i,
  input  logic              ev_fatal_i,
  input  logic              ev_unsup_i,
  input  logic              unsup_sev_fatal_i,
  input  logic [3:0]        rpt_en_i,
  input  logic [MASK_W-1:0] uncor_mask_i,
  input  logic [MASK_W-1:0] cor_mask_i
);
  localparam int STS_LANE = 2;
  localparam int LSB      = STS_LANE * 8;

  err_vec_t set_v, clr_v, sts_q;

  dsts_evt_route i_route (
    .ev_corr_i         (ev_corr_i),
    .ev_nonfatal_i     (ev_nonfatal_i),
    .ev_fatal_i        (ev_fatal_i),
    .ev_unsup_i        (ev_unsup_i),
    .unsup_sev_fatal_i (unsup_sev_fatal_i),
    .set_o             (set_v)
  );

  dsts_cfg_port #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .STS_LANE(STS_LANE)) i_port (
    .addr_i  (cfg_addr_i),
    .wr_i    (cfg_wr_i),
    .be_i    (cfg_be_i),
    .wdata_i (cfg_wdata_i),
    .sts_i   (sts_q),
    .clr_o   (clr_v),
    .rdata_o (cfg_rdata_o)
  );

  for (genvar g = 0; g < N_ERR; g++) begin : g_bit
    dsts_w1c_bit i_bit (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_v[g]),
      .clr_i  (clr_v[g]),
      .q_o    (sts_q[g])
    );
  end

  // reserved, TP and lower half never read 1
  a_r8_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rdata_o[31:LSB+N_ERR] == '0) && (cfg_rdata_o[LSB-1:0] == '0));
  a_r2_miss_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_addr_i[ADDR_W-1:2] != REG_ADDR[ADDR_W-1:2]) |-> (cfg_rdata_o == '0));
  a_r4_unsup_fatal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_unsup_i && unsup_sev_fatal_i) |=> (sts_q[B_FAT] && sts_q[B_UNSUP]));
  a_r4_unsup_nonfatal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_unsup_i && !unsup_sev_fatal_i) |=> (sts_q[B_NFAT] && sts_q[B_UNSUP]));
  a_r9_corr_unmasked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_corr_i && ((rpt_en_i != 4'h0) || (cor_mask_i != '0))) |=> sts_q[B_CORR]);
  a_r9_fatal_unmasked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_fatal_i && (uncor_mask_i != '0)) |=> sts_q[B_FAT]);
  a_r6_lane_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_wr_i && !cfg_be_i[STS_LANE] && (set_v == '0)) |=> $stable(sts_q));
  a_r10_read_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_wr_i && (set_v == '0) && (cfg_wdata_i != 32'h1) && (cfg_addr_i[1:0] != 2'h3))
      |=> $stable(sts_q));
endmodule

// File: tb/test_dsts_err_log.sv
module test_dsts_err_log;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = 12'hA8;
  logic        wr = 1'b0;
  logic [3:0]  be = 4'h0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ec = 0, enf = 0, ef = 0, eu = 0, sev = 0;
  logic [3:0]  rpt_en = 4'hF;
  logic [31:0] umask = '0, cmask = '0;

  int checks = 0, errors = 0;
  logic [3:0] model = '0;

  always #2 clk = ~clk;

  dsts_err_log i_dsts_err_log (
    .clk_i(clk), .rst_ni(rst_n), .cfg_addr_i(addr), .cfg_wr_i(wr), .cfg_be_i(be),
    .cfg_wdata_i(wdata), .cfg_rdata_o(rdata), .ev_corr_i(ec), .ev_nonfatal_i(enf),
    .ev_fatal_i(ef), .ev_unsup_i(eu), .unsup_sev_fatal_i(sev), .rpt_en_i(rpt_en),
    .uncor_mask_i(umask), .cor_mask_i(cmask)
  );

  function automatic logic [31:0] exp_rd(input logic [11:0] a, input logic [3:0] m);
    return (a[11:2] == 10'h2A) ? {12'h000, m, 16'h0000} : 32'h0;
  endfunction

  function automatic logic [3:0] next_model(input logic [3:0] m, input logic c, nf, f, u, s,
      input logic w, input logic [11:0] a, input logic [3:0] b, input logic [31:0] d);
    logic [3:0] st, cl;
    st = {u, f | (u & s), nf | (u & ~s), c};
    cl = (w && a[11:2] == 10'h2A && b[2]) ? d[19:16] : 4'h0;
    return st | (m & ~cl);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic step(input logic c, nf, f, u, s, input logic w, input logic [11:0] a,
      input logic [3:0] b, input logic [31:0] d, input string tag);
    ec = c; enf = nf; ef = f; eu = u; sev = s; wr = w; addr = a; be = b; wdata = d;
    #1 chk({tag, " R2 R10 pre-edge read"}, rdata, exp_rd(a, model));
    model = next_model(model, c, nf, f, u, s, w, a, b, d);
    @(posedge clk);
    @(negedge clk);
    ec = 0; enf = 0; ef = 0; eu = 0; wr = 0; addr = 12'hA8;
    #1 chk(tag, rdata, exp_rd(12'hA8, model));
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    #1 chk("R1 reset value", rdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    #1 chk("R1 after release", rdata, 32'h0);

    step(1,0,0,0,0, 0,12'hA8,4'h0,32'h0, "R3 correctable");
    step(0,0,0,0,0, 0,12'hA8,4'h0,32'h0, "R10 reread no side effect");
    step(0,0,0,1,0, 0,12'hA8,4'h0,32'h0, "R4 unsup non-fatal");
    step(0,0,0,0,0, 1,12'hA8,4'h4,32'h0008_0000, "R5 clear bit3 only");
    step(0,0,0,0,0, 1,12'hA8,4'h4,32'h0000_0000, "R5 write zeros no effect");
    step(0,0,0,1,1, 0,12'hA8,4'h0,32'h0, "R4 unsup fatal");
    step(0,0,0,0,0, 1,12'hA8,4'hB,32'hFFFF_FFFF, "R6 lane2 disabled");
    step(0,0,0,0,0, 1,12'hAC,4'hF,32'hFFFF_FFFF, "R6 other address");
    step(1,0,0,0,0, 1,12'hA8,4'h4,32'h0001_0000, "R7 set beats clear");
    step(0,0,0,0,0, 1,12'hA8,4'hF,32'hFFFF_FFFF, "R8 R5 all ones write");
    chk("R8 reserved and TP zero", rdata, 32'h0);
    rpt_en = 4'h0; umask = '1; cmask = '1;
    step(1,1,1,0,0, 0,12'hA8,4'h0,32'h0, "R11 R9 multi events masked");
    step(0,0,0,0,0, 1,12'hA8,4'h4,32'h0002_0000, "R5 clear nonfatal keeps others");
    step(0,0,0,0,0, 0,12'h0A8 ^ 12'h100,4'h0,32'h0, "R2 aliased miss");
    step(0,0,0,0,0, 0,12'hAB,4'h0,32'h0, "R2 byte address in dword");

    for (int i = 0; i < 3000; i++) begin
      logic [11:0] a;
      a = ($urandom % 2) ? 12'hA8 : 12'($urandom % 256);
      rpt_en = 4'($urandom); umask = $urandom; cmask = $urandom;
      step(($urandom % 4) == 0, ($urandom % 5) == 0, ($urandom % 6) == 0, ($urandom % 5) == 0,
           1'($urandom), ($urandom % 3) == 0, a, 4'($urandom), $urandom,
           "R3 R4 R5 R6 R7 R11 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule